// File: doc/BRIEF.md
# Coarse Depth and Stencil Quad Culler

This block rejects quads that a coarse occlusion record proves cannot be visible. Each time a tile of 8x8 pixels leaves triangle traversal, the tile arrives as sixteen 2x2 quads. Each quad carries a conservative minimum depth, a four-bit pixel coverage mask and a stencil-pass hint. In a single cycle the block tests all sixteen quads in parallel against a table of coarse records. It returns a 16-bit keep mask, so traversal can discard the occluded quads before shading.

A coarse record covers the 16 samples of one quad (four samples per pixel). It holds two fields: an 11-bit quantized maximum depth and a stencil-fail flag. The quantized depth is floored on the quad side and ceiled on the record side, so a reject is never wrong. Update writes can only tighten a stored maximum, and they can also raise the stencil flag. A clear pulse resets every record to the far value with the flag low.

The tile input and the keep-mask output use valid/ready handshakes. A result waits in the output register until it is taken. While that result is stalled, `tile_ready` stays low, so back-pressure reaches traversal with no loss and no reordering. The update and clear pins are plain control pins. They have no handshake and act in the cycle in which they are asserted.

Top module: `hz_quad_cull`

## Requirements
- R1: After reset, `keep_valid` is 0 and `tile_ready` is 1. Every record holds the far value 2047 with its stencil flag clear, so a fully covered quad of any depth is kept.
- R2: A tile is accepted on a clock edge where `tile_valid` and `tile_ready` are both high. `keep_valid` rises on that edge, and `keep_tile` echoes the tile's `tile_id`. `tile_ready` is low exactly when `keep_valid` is high and `keep_ready` is low. While stalled, `keep_mask` and `keep_tile` hold their values.
- R3: Quad q uses bits [q*24 +: 24] of `tile_zmin`, and its result is bit q of `keep_mask`. Quad q is rejected (bit 0) when bits [23:13] of its minimum depth exceed the stored maximum of record (tile, q).
- R4: The low 13 bits of a quad's minimum depth never cause a reject. A quad whose top 11 bits equal the stored maximum is kept.
- R5: An update write sets the stored maximum to the smaller of the old value and the rounded-up form of `upd_zmax`. Rounding up means bits [23:13], plus one when any of bits [12:0] is set, saturating at 2047. A looser value leaves the record unchanged.
- R6: An update with `upd_sten_fail` high sets the record's stencil flag. Nothing but a clear lowers it. A quad whose record flag is set is rejected unless its hint bit `tile_sten_pass[q]` is 1.
- R7: A quad whose coverage bits `tile_cov[q*4 +: 4]` are all zero is always rejected.
- R8: `clr` returns every record to maximum 2047 and stencil flag 0. It takes priority over an update in the same cycle.
- R9: A tile accepted in the same cycle as an update or clear is tested against the records as they stood before that cycle's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tile_valid | input | 1 | Tile presented |
| tile_ready | output | 1 | Block can take a tile this cycle |
| tile_id | input | TILE_W (4) | Tile index into the record table |
| tile_zmin | input | 16*ZIN_W (384) | Per-quad conservative minimum depth |
| tile_cov | input | 64 | Per-quad 4-bit pixel coverage |
| tile_sten_pass | input | 16 | Per-quad hint: stencil known to pass |
| keep_valid | output | 1 | Keep mask available |
| keep_ready | input | 1 | Consumer takes the keep mask |
| keep_mask | output | 16 | Bit q high: quad q survives |
| keep_tile | output | TILE_W (4) | Tile index of the current keep mask |
| upd_en | input | 1 | Apply one record update this cycle |
| upd_tile | input | TILE_W (4) | Tile of the record to update |
| upd_quad | input | 4 | Quad of the record to update |
| upd_zmax | input | ZIN_W (24) | New full-precision maximum depth |
| upd_sten_fail | input | 1 | Mark record as stencil-failing |
| clr | input | 1 | Reset all records to far |

## Verification
A keep mask is due one edge after its tile is accepted. The bench therefore drives on the falling edge and reads `keep_mask` at the next falling edge. The expected mask is taken from the reference table as it stood when the tile was driven. An update or clear changes the records on the edge where it is driven, so the bench updates its table only after that edge. A tile driven in the same cycle as a write is thus checked against the old record values. Under a stall, the bench reads the held output on each following falling edge, and it checks that `tile_ready` falls in the same cycle the stall begins.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int QUADS   = 16;
  localparam int QPIX    = 4;
  localparam int QUAD_W  = $clog2(QUADS);
  localparam int CZ_W    = 11;
  localparam logic [CZ_W-1:0] CZ_FAR = '1;

  typedef struct packed {
    logic            sten_fail;
    logic [CZ_W-1:0] zmax;
  } hz_rec_t;

  localparam hz_rec_t REC_FAR = '{sten_fail: 1'b0, zmax: CZ_FAR};
endpackage

// File: rtl/hz_zceil.sv
// Upward quantization of a full-precision depth to the coarse width.
module hz_zceil
  import hz_pkg::*;
#(
  parameter int ZIN_W = 24
) (
  input  logic [ZIN_W-1:0] z,
  output logic [CZ_W-1:0]  zq
);
  localparam int LO_W = ZIN_W - CZ_W;

  logic [CZ_W-1:0] hi;
  logic            frac;

  assign hi   = z[ZIN_W-1 -: CZ_W];
  assign frac = |z[LO_W-1:0];
  // Saturate at the far value so the ceiling never wraps to near.
  assign zq   = (frac && hi != CZ_FAR) ? hi + CZ_W'(1) : hi;
endmodule

// File: rtl/hz_record_store.sv
// Coarse record table: TILES x QUADS entries, combinational tile read.
module hz_record_store
  import hz_pkg::*;
#(
  parameter int TILES  = 16,
  parameter int TILE_W = $clog2(TILES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd_en,
  input  logic [TILE_W-1:0] upd_tile,
  input  logic [QUAD_W-1:0] upd_quad,
  input  logic [CZ_W-1:0]   upd_zq,
  input  logic              upd_sten_fail,
  input  logic [TILE_W-1:0] rd_tile,
  output hz_rec_t           rd_recs [QUADS]
);
  hz_rec_t recs_all [TILES][QUADS];

  for (genvar t = 0; t < TILES; t++) begin : g_tile
    for (genvar q = 0; q < QUADS; q++) begin : g_quad
      hz_rec_t rec_q;
      logic    hit;

      assign hit = upd_en && (upd_tile == TILE_W'(t)) && (upd_quad == QUAD_W'(q));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rec_q <= REC_FAR;
        end else if (clr) begin
          rec_q <= REC_FAR;
        end else if (hit) begin
          if (upd_zq < rec_q.zmax) rec_q.zmax <= upd_zq;
          if (upd_sten_fail)       rec_q.sten_fail <= 1'b1;
        end
      end

      assign recs_all[t][q] = rec_q;
    end
  end

  always_comb begin
    for (int q = 0; q < QUADS; q++) rd_recs[q] = recs_all[rd_tile][q];
  end
endmodule

// File: rtl/hz_quad_test.sv
// Sixteen parallel conservative occlusion and stencil tests.
module hz_quad_test
  import hz_pkg::*;
#(
  parameter int ZIN_W = 24
) (
  input  logic [QUADS*ZIN_W-1:0] zmin,
  input  logic [QUADS*QPIX-1:0]  cov,
  input  logic [QUADS-1:0]       sten_pass,
  input  hz_rec_t                recs [QUADS],
  output logic [QUADS-1:0]       keep
);
  localparam int LO_W = ZIN_W - CZ_W;

  for (genvar q = 0; q < QUADS; q++) begin : g_q
    logic [ZIN_W-1:0] zq_lim;
    logic             depth_ok;
    logic             sten_ok;
    logic             covered;

    // floor(zmin) <= zmax is the same as zmin <= {zmax, all ones}.
    assign zq_lim   = {recs[q].zmax, {LO_W{1'b1}}};
    assign depth_ok = zmin[q*ZIN_W +: ZIN_W] <= zq_lim;
    assign sten_ok  = !recs[q].sten_fail || sten_pass[q];
    assign covered  = |cov[q*QPIX +: QPIX];
    assign keep[q]  = covered && depth_ok && sten_ok;
  end
endmodule

// File: rtl/hz_quad_cull.sv
module hz_quad_cull
  import hz_pkg::*;
#(
  parameter int ZIN_W  = 24,
  parameter int TILES  = 16,
  localparam int TILE_W = $clog2(TILES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tile_valid,
  output logic                   tile_ready,
  input  logic [TILE_W-1:0]      tile_id,
  input  logic [QUADS*ZIN_W-1:0] tile_zmin,
  input  logic [QUADS*QPIX-1:0]  tile_cov,
  input  logic [QUADS-1:0]       tile_sten_pass,
  output logic                   keep_valid,
  input  logic                   keep_ready,
  output logic [QUADS-1:0]       keep_mask,
  output logic [TILE_W-1:0]      keep_tile,
  input  logic                   upd_en,
  input  logic [TILE_W-1:0]      upd_tile,
  input  logic [QUAD_W-1:0]      upd_quad,
  input  logic [ZIN_W-1:0]       upd_zmax,
  input  logic                   upd_sten_fail,
  input  logic                   clr
);
  logic [CZ_W-1:0]  upd_zq;
  hz_rec_t          recs [QUADS];
  logic [QUADS-1:0] keep_c;
  logic             accept;

  hz_zceil #(.ZIN_W(ZIN_W)) u_ceil (
    .z  (upd_zmax),
    .zq (upd_zq)
  );

  hz_record_store #(.TILES(TILES), .TILE_W(TILE_W)) u_store (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr           (clr),
    .upd_en        (upd_en),
    .upd_tile      (upd_tile),
    .upd_quad      (upd_quad),
    .upd_zq        (upd_zq),
    .upd_sten_fail (upd_sten_fail),
    .rd_tile       (tile_id),
    .rd_recs       (recs)
  );

  hz_quad_test #(.ZIN_W(ZIN_W)) u_test (
    .zmin      (tile_zmin),
    .cov       (tile_cov),
    .sten_pass (tile_sten_pass),
    .recs      (recs),
    .keep      (keep_c)
  );

  assign tile_ready = !keep_valid || keep_ready;
  assign accept     = tile_valid && tile_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keep_valid <= 1'b0;
      keep_mask  <= '0;
      keep_tile  <= '0;
    end else if (accept) begin
      keep_valid <= 1'b1;
      keep_mask  <= keep_c;
      keep_tile  <= tile_id;
    end else if (keep_ready) begin
      keep_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/hz_quad_cull_chk.sv
module hz_quad_cull_chk
  import hz_pkg::*;
#(
  parameter int TILE_W = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tile_valid,
  input logic                  tile_ready,
  input logic [QUADS*QPIX-1:0] tile_cov,
  input logic                  keep_valid,
  input logic                  keep_ready,
  input logic [QUADS-1:0]      keep_mask,
  input logic [TILE_W-1:0]     keep_tile
);
  logic [QUADS-1:0] cov_any;
  always_comb begin
    for (int q = 0; q < QUADS; q++) cov_any[q] = |tile_cov[q*QPIX +: QPIX];
  end

  p_stall_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (keep_valid && !keep_ready) |-> !tile_ready);

  p_hold_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (keep_valid && !keep_ready) |=> (keep_valid && $stable(keep_mask) && $stable(keep_tile)));

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tile_valid && tile_ready) |=> keep_valid);

  p_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tile_valid && keep_ready) |=> !keep_valid);

  p_no_cov_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tile_valid && tile_ready) |=> ((keep_mask & ~$past(cov_any)) == '0));
endmodule

bind hz_quad_cull hz_quad_cull_chk #(.TILE_W(TILE_W)) u_chk (.*);

// File: tb/sim_hz_quad_cull.sv
`timescale 1ns/1ps
module sim_hz_quad_cull;
  localparam int ZW = 24;
  localparam int NT = 16;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tile_valid = 0, keep_ready = 1, upd_en = 0, upd_sten_fail = 0, clr = 0;
  logic [TW-1:0] tile_id = '0, upd_tile = '0;
  logic [3:0] upd_quad = '0;
  logic [ZW-1:0] upd_zmax = '0;
  logic [16*ZW-1:0] zbus = '0;
  logic [63:0] covbus = '0;
  logic [15:0] hintbus = '0;
  logic tile_ready, keep_valid;
  logic [15:0] keep_mask;
  logic [TW-1:0] keep_tile;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [10:0] ref_max [NT][16];
  bit          ref_st  [NT][16];

  always #4 clk = ~clk;

  hz_quad_cull #(.ZIN_W(ZW), .TILES(NT)) u0 (
    .clk(clk), .rst_n(rst_n), .tile_valid(tile_valid), .tile_ready(tile_ready),
    .tile_id(tile_id), .tile_zmin(zbus), .tile_cov(covbus), .tile_sten_pass(hintbus),
    .keep_valid(keep_valid), .keep_ready(keep_ready), .keep_mask(keep_mask),
    .keep_tile(keep_tile), .upd_en(upd_en), .upd_tile(upd_tile), .upd_quad(upd_quad),
    .upd_zmax(upd_zmax), .upd_sten_fail(upd_sten_fail), .clr(clr));

  function automatic logic [10:0] qceil(logic [ZW-1:0] z);
    logic [10:0] h = z[23:13];
    if (z[12:0] != 0 && h != 11'h7FF) h = h + 11'd1;
    return h;
  endfunction

  function automatic logic [15:0] model_mask(int t);
    logic [15:0] m;
    for (int q = 0; q < 16; q++) begin
      logic [ZW-1:0] z = zbus[q*ZW +: ZW];
      m[q] = (|covbus[q*4 +: 4]) && (z[23:13] <= ref_max[t][q]) &&
             (!ref_st[t][q] || hintbus[q]);
    end
    return m;
  endfunction

  task automatic model_clear();
    for (int t = 0; t < NT; t++)
      for (int q = 0; q < 16; q++) begin ref_max[t][q] = 11'h7FF; ref_st[t][q] = 0; end
  endtask

  task automatic model_update();
    logic [10:0] c = qceil(upd_zmax);
    if (clr) model_clear();
    else if (upd_en) begin
      if (c < ref_max[upd_tile][upd_quad]) ref_max[upd_tile][upd_quad] = c;
      if (upd_sten_fail) ref_st[upd_tile][upd_quad] = 1;
    end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic fill(logic [ZW-1:0] z, logic [63:0] c, logic [15:0] h);
    for (int q = 0; q < 16; q++) zbus[q*ZW +: ZW] = z;
    covbus = c; hintbus = h;
  endtask

  // Drive a tile, with optional concurrent write already set on the pins.
  task automatic tile_go(logic [TW-1:0] id, string req);
    logic [15:0] e;
    tile_id = id; tile_valid = 1;
    e = model_mask(id);
    step();
    model_update();
    tile_valid = 0; upd_en = 0; clr = 0; upd_sten_fail = 0;
    chk(req, {31'd0, keep_valid}, 32'd1);
    chk(req, {16'd0, keep_mask}, {16'd0, e});
    chk(req, {28'd0, keep_tile}, {28'd0, id});
  endtask

  task automatic upd_go(logic [TW-1:0] t, logic [3:0] q, logic [ZW-1:0] z, logic sf);
    upd_en = 1; upd_tile = t; upd_quad = q; upd_zmax = z; upd_sten_fail = sf;
    step();
    model_update();
    upd_en = 0; upd_sten_fail = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] e1, e2;
    void'($urandom(32'd2024));
    model_clear();
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {31'd0, keep_valid}, 32'd0);
    chk("R1", {31'd0, tile_ready}, 32'd1);
    fill(24'hFFFFFF, '1, '0);
    tile_go(4'd0, "R1");
    chk("R1", {16'd0, keep_mask}, 32'h0000FFFF);

    // R3/R4 depth reject at the quantized boundary
    upd_go(4'd0, 4'd3, 24'h100000, 0);
    fill(24'h101FFF, '1, '0);
    tile_go(4'd0, "R4");
    chk("R4", {31'd0, keep_mask[3]}, 32'd1);
    fill(24'h102000, '1, '0);
    tile_go(4'd0, "R3");
    chk("R3", {31'd0, keep_mask[3]}, 32'd0);

    // R5 ceiling of update and tighten-only
    upd_go(4'd0, 4'd5, 24'h100001, 0);
    upd_go(4'd0, 4'd3, 24'h200000, 0);
    fill(24'h102000, '1, '0);
    tile_go(4'd0, "R5");
    chk("R5", {30'd0, keep_mask[5], keep_mask[3]}, 32'd2);
    upd_go(4'd0, 4'd6, 24'hFFFFFF - 24'd1, 0);
    fill(24'hFFFFFF, '1, '0);
    tile_go(4'd0, "R5");
    chk("R5", {31'd0, keep_mask[6]}, 32'd1);

    // R6 stencil flag and hint
    upd_go(4'd1, 4'd7, 24'hFFFFFF, 1);
    fill(24'h000000, '1, '0);
    tile_go(4'd1, "R6");
    chk("R6", {31'd0, keep_mask[7]}, 32'd0);
    fill(24'h000000, '1, 16'h0080);
    tile_go(4'd1, "R6");
    chk("R6", {31'd0, keep_mask[7]}, 32'd1);

    // R7 empty coverage
    fill(24'h000000, 64'hFFFF_FF0F_FFFF_FFFF, '1);
    tile_go(4'd2, "R7");
    chk("R7", {16'd0, keep_mask}, 32'h0000FDFF);

    // R9 tile sees pre-write records
    fill(24'h180000, '1, '0);
    upd_en = 1; upd_tile = 4'd2; upd_quad = 4'd0; upd_zmax = 24'h010000;
    tile_go(4'd2, "R9");
    chk("R9", {31'd0, keep_mask[0]}, 32'd1);
    tile_go(4'd2, "R9");
    chk("R9", {31'd0, keep_mask[0]}, 32'd0);

    // R8 clear wins over same-cycle update
    clr = 1; upd_en = 1; upd_tile = 4'd0; upd_quad = 4'd9; upd_zmax = 24'h0; upd_sten_fail = 1;
    step();
    model_update();
    clr = 0; upd_en = 0; upd_sten_fail = 0;
    fill(24'hFFFFFF, '1, '0);
    tile_go(4'd0, "R8");
    chk("R8", {16'd0, keep_mask}, 32'h0000FFFF);
    tile_go(4'd1, "R8");
    chk("R8", {16'd0, keep_mask}, 32'h0000FFFF);

    // R2 back-pressure
    upd_go(4'd3, 4'd0, 24'h000000, 0);
    keep_ready = 0;
    fill(24'h100000, '1, '0);
    tile_id = 4'd3; tile_valid = 1;
    e1 = model_mask(3);
    step();
    tile_id = 4'd4; zbus[0 +: ZW] = 24'hFFFFFF;
    e2 = model_mask(4);
    chk("R2", {31'd0, tile_ready}, 32'd0);
    chk("R2", {16'd0, keep_mask}, {16'd0, e1});
    step();
    chk("R2", {16'd0, keep_mask}, {16'd0, e1});
    chk("R2", {28'd0, keep_tile}, 32'd3);
    keep_ready = 1;
    #1 chk("R2", {31'd0, tile_ready}, 32'd1);
    step();
    tile_valid = 0;
    chk("R2", {16'd0, keep_mask}, {16'd0, e2});
    chk("R2", {28'd0, keep_tile}, 32'd4);
    step();
    chk("R2", {31'd0, keep_valid}, 32'd0);

    // Random mix of updates, tiles, same-cycle writes and rare clears
    for (int i = 0; i < 600; i++) begin
      int op = $urandom % 16;
      if (op < 5 || (op >= 10 && op < 15)) begin
        upd_en = 1; upd_tile = TW'($urandom % 4); upd_quad = 4'($urandom);
        upd_zmax = {11'h080 + 11'($urandom % 24), 13'($urandom)};
        if ($urandom % 4 == 0) upd_zmax[12:0] = '0;
        upd_sten_fail = ($urandom % 10 == 0);
      end
      if (op == 15) clr = 1;
      if (op >= 5) begin
        for (int q = 0; q < 16; q++) begin
          zbus[q*ZW +: ZW] = {11'h080 + 11'($urandom % 24), 13'($urandom)};
          covbus[q*4 +: 4] = ($urandom % 6 == 0) ? 4'h0 : 4'($urandom);
        end
        hintbus = 16'($urandom);
        tile_go(TW'($urandom % 4), "R3");
      end else begin
        step();
        model_update();
        upd_en = 0; upd_sten_fail = 0; clr = 0;
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule